// File: doc/BRIEF.md
# Add-With-Carry Execution Unit

This block executes the 8-bit add-with-carry instruction family for a small 8-bit processor core. It owns the accumulator, six general registers (B, C, D, E, H, L) and the flag register. When the surrounding core raises `start`, the unit fetches one opcode byte at the program counter. It decodes the opcode and picks an operand from a register, from the immediate byte after the opcode, or from memory at the address held in the H:L pair. It then writes the 8-bit sum of accumulator, operand and carry flag back into the accumulator and recomputes the flags.

A memory read is a strobe cycle followed by a data cycle, and the read data arrives one clock after `mem_rd`. One machine cycle is therefore two clocks. Register forms retire after one machine cycle. The immediate and H:L-indirect forms retire after two. A byte that is not one of the nine recognised opcodes pulses `illegal` and leaves all architectural state untouched. A simple register-load port lets the rest of the core preset the register file while the unit is idle.

Top module: `addc_exec_unit`

## Requirements
- R1: The accumulator receives (A + operand + carry flag) modulo 256.
- R2: At every retirement, the subtract flag (flags bit 6) reads 0 and the zero flag (flags bit 7) is 1 exactly when the new accumulator is 0x00.
- R3: The carry flag (flags bit 4) is set when the 9-bit sum A + operand + carry-in exceeds 0xFF, and cleared otherwise.
- R4: The half-carry flag (flags bit 5) is set when (A & 0xF) + (operand & 0xF) + carry-in exceeds 0xF. For example, 0x0F + 0x00 with carry-in 1 sets only this flag.
- R5: Flags bits 3..0 always read 0, including after reset (A, flags and all registers reset to 0x00) and after a flags load.
- R6: Opcodes 0x88..0x8D select B, C, D, E, H, L, and 0x8F selects A. After `start` is sampled, these forms drop `busy` and pulse `done` for one clock at the second rising edge, and the program counter advances by 1.
- R7: Opcode 0xCE issues a second read at the address right after the opcode. Its result is due at the fourth rising edge after `start`, and the program counter advances by 2.
- R8: Opcode 0x8E issues a second read at address {H, L}. Its result is due at the fourth rising edge after `start`, and the program counter advances by 1.
- R9: Any other opcode pulses `illegal` (without `done`) at the second rising edge. A, flags and the program counter are unchanged.
- R10: The load port writes `ld_data` to register `ld_sel` (0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=flags, 7=A) only while idle with `start` low. It is ignored while busy.
- R11: `mem_rd` rises in the same cycle as an accepted `start`, with `mem_addr` equal to the program counter. Read data is taken one clock after each strobe.
- R12: `start` is ignored while the unit is busy and issues no extra fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction (fetch at PC) |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-clock retirement pulse |
| illegal | output | 1 | One-clock pulse for an unrecognised opcode |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one clock after the strobe |
| ld_en | input | 1 | Register load enable |
| ld_sel | input | 3 | Register select for loads |
| ld_data | input | 8 | Register load data |
| acc | output | 8 | Accumulator |
| flags | output | 8 | Flag register {Z, N, H, C, 0000} |
| pc | output | 16 | Program counter |

## Verification
Register forms and unrecognised opcodes settle at the second rising edge after `start` is sampled, and the memory forms settle at the fourth. The second read strobe of the memory forms is visible in the cycle after the opcode's data cycle. The bench drives on falling edges and walks a per-instruction timeline. At each falling edge it compares `busy`, `done`, `illegal`, `mem_rd` and `mem_addr` against that timeline. At the edge where retirement is due, it also compares `acc`, `flags` and `pc` with a behavioural model. During the busy window it holds `start` and the load port active to show that neither leaves a trace.

// File: rtl/addc_exec_unit.sv
module addc_exec_unit #(
  parameter logic [15:0] PC_RESET = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  input  logic        ld_en,
  input  logic [2:0]  ld_sel,
  input  logic [7:0]  ld_data,
  output logic [7:0]  acc,
  output logic [7:0]  flags,
  output logic [15:0] pc
);

  localparam logic [7:0] OP_IMM = 8'hCE;
  localparam logic [7:0] OP_HL  = 8'h8E;
  localparam int         IX_F   = 6;
  localparam int         IX_A   = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_OP, ST_MRD, ST_MEX} st_t;

  st_t        st;
  logic [7:0] rf [8];
  logic [7:0] opc_q;
  logic [15:0] pc_q;
  logic       done_q, ill_q;

  logic       is_reg, is_mem;
  logic [7:0] opnd;
  logic [8:0] sum;
  logic [4:0] hsum;
  logic [7:0] f_new;

  assign is_reg = (mem_rdata[7:3] == 5'b10001) && (mem_rdata[2:0] != 3'b110);
  assign is_mem = (mem_rdata == OP_IMM) || (mem_rdata == OP_HL);
  assign opnd   = (st == ST_MEX) ? mem_rdata : rf[mem_rdata[2:0]];
  assign sum    = {1'b0, rf[IX_A]} + {1'b0, opnd} + {8'd0, rf[IX_F][4]};
  assign hsum   = {1'b0, rf[IX_A][3:0]} + {1'b0, opnd[3:0]} + {4'd0, rf[IX_F][4]};
  assign f_new  = {sum[7:0] == 8'h00, 1'b0, hsum[4], sum[8], 4'h0};

  assign mem_rd   = (st == ST_IDLE && start) || st == ST_MRD;
  assign mem_addr = (st != ST_MRD) ? pc_q :
                    (opc_q == OP_IMM) ? pc_q : {rf[4], rf[5]};

  assign busy    = (st != ST_IDLE);
  assign done    = done_q;
  assign illegal = ill_q;
  assign acc     = rf[IX_A];
  assign flags   = rf[IX_F];
  assign pc      = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pc_q   <= PC_RESET;
      opc_q  <= 8'h00;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      for (int i = 0; i < 8; i++) rf[i] <= 8'h00;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) st <= ST_OP;
          else if (ld_en)
            rf[ld_sel] <= (ld_sel == 3'(IX_F)) ? {ld_data[7:4], 4'h0} : ld_data;
        end
        ST_OP: begin
          opc_q <= mem_rdata;
          if (is_reg) begin
            pc_q     <= pc_q + 16'd1;
            rf[IX_A] <= sum[7:0];
            rf[IX_F] <= f_new;
            done_q   <= 1'b1;
            st       <= ST_IDLE;
          end else if (is_mem) begin
            pc_q <= pc_q + 16'd1;
            st   <= ST_MRD;
          end else begin
            ill_q <= 1'b1;
            st    <= ST_IDLE;
          end
        end
        ST_MRD: begin
          if (opc_q == OP_IMM) pc_q <= pc_q + 16'd1;
          st <= ST_MEX;
        end
        ST_MEX: begin
          rf[IX_A] <= sum[7:0];
          rf[IX_F] <= f_new;
          done_q   <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_low_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3:0] == 4'h0);

  p_sub_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flags[6]);

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags[7] == (acc == 8'h00)));

  p_retire_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done || illegal) |-> !busy && !(done && illegal));

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(acc) && $stable(flags) && $stable(pc));

  p_busy_from_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_strobe_then_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> busy);

endmodule

// File: tb/sim_addc_exec_unit.sv
`timescale 1ns/1ps
module sim_addc_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, illegal, mem_rd;
  logic [15:0] mem_addr, pc;
  logic [7:0]  mem_rdata = 8'h00;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_sel = 3'd0;
  logic [7:0]  ld_data = 8'h00;
  logic [7:0]  acc, flags;

  int tests = 0;
  int fails = 0;
  logic [7:0] mem [256];
  logic [7:0] r [8];
  logic [15:0] mpc;

  always #4 clk = ~clk;

  addc_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .illegal(illegal), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .acc(acc), .flags(flags), .pc(pc)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic load(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    r[sel] = (sel == 3'd6) ? {d[7:4], 4'h0} : d;
    if (sel == 3'd6) chk("R5", "flags after load", flags, r[6]);
    if (sel == 3'd7) chk("R10", "acc after load", acc, r[7]);
  endtask

  task automatic run(input logic [7:0] opc, input logic [7:0] imm, input bit hold);
    bit legal, memf;
    int L, s, h;
    logic [7:0] op, res, ef;
    logic [15:0] p0, eaddr, epc;
    p0 = mpc;
    mem[p0[7:0]] = opc;
    if (opc == 8'hCE) mem[p0[7:0] + 8'd1] = imm;
    memf  = (opc == 8'hCE) || (opc == 8'h8E);
    legal = memf || ((opc[7:3] == 5'b10001) && (opc[2:0] != 3'b110));
    L = memf ? 4 : 2;
    op = (opc == 8'hCE) ? imm : (opc == 8'h8E) ? mem[r[5]] : r[opc[2:0]];
    eaddr = (opc == 8'hCE) ? p0 + 16'd1 : {r[4], r[5]};
    s = int'(r[7]) + int'(op) + int'(r[6][4]);
    h = int'(r[7][3:0]) + int'(op[3:0]) + int'(r[6][4]);
    res = s[7:0];
    ef = {res == 8'h00, 1'b0, h > 15, s > 255, 4'h0};
    epc = !legal ? p0 : (opc == 8'hCE) ? p0 + 16'd2 : p0 + 16'd1;
    @(negedge clk);
    start = 1'b1;
    #1;
    chk("R11", "fetch strobe", {15'd0, mem_rd}, 32'd1);
    chk("R11", "fetch addr", mem_addr, p0);
    for (int k = 1; k <= L; k++) begin
      @(negedge clk);
      start = hold && (k < L - 1);
      ld_en = hold && (k == 1); ld_sel = 3'd7; ld_data = 8'h5A;
      #1;
      if (k < L) begin
        chk("R6", "busy mid", {31'd0, busy}, 32'd1);
        chk("R6", "done mid", {31'd0, done}, 32'd0);
        if (memf && k == 2) begin
          chk(opc == 8'hCE ? "R7" : "R8", "operand strobe", {31'd0, mem_rd}, 32'd1);
          chk(opc == 8'hCE ? "R7" : "R8", "operand addr", mem_addr, eaddr);
        end else chk("R12", "no extra strobe", {31'd0, mem_rd}, 32'd0);
      end else begin
        chk("R6", "busy end", {31'd0, busy}, 32'd0);
        chk(legal ? "R6" : "R9", "done", {31'd0, done}, {31'd0, legal});
        chk("R9", "illegal", {31'd0, illegal}, {31'd0, !legal});
        chk("R12", "no refetch", {31'd0, mem_rd}, 32'd0);
        if (legal) begin
          r[7] = res; r[6] = ef;
        end
        chk("R1", "acc", acc, r[7]);
        chk("R3", "flags", flags, r[6]);
        chk(memf ? (opc == 8'hCE ? "R7" : "R8") : "R6", "pc", pc, epc);
      end
    end
    ld_en = 1'b0;
    mpc = epc;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) r[i] = 8'h00;
    mpc = 16'h0000;
    mem[8'hC4] = 8'h7F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", "reset flags", flags, 0);
    chk("R5", "reset acc", acc, 0);
    chk("R6", "reset busy", {31'd0, busy}, 0);
    chk("R6", "reset pc", pc, 0);

    load(0, 8'h00); load(1, 8'h3C); load(2, 8'h80); load(3, 8'h01);
    load(4, 8'h12); load(5, 8'hC4); load(7, 8'hFF); load(6, 8'h10);
    run(8'h88, 8'h00, 0);               // R2 R3 R4: FF+00+1 -> 00, F=B0
    chk("R2", "zero wrap", flags, 8'hB0);
    load(7, 8'h0F); load(6, 8'h10);
    run(8'h88, 8'h00, 0);               // R4: half-carry only
    chk("R4", "half only", flags, 8'h20);
    load(7, 8'h80); load(6, 8'h00);
    run(8'h8A, 8'h00, 0);
    run(8'h8B, 8'h00, 0);
    run(8'h89, 8'h00, 0);
    run(8'h8F, 8'h00, 0);
    run(8'h8C, 8'h00, 0);
    run(8'h8D, 8'h00, 1);
    run(8'hCE, 8'hF0, 1);               // R7
    run(8'h8E, 8'h00, 1);               // R8
    run(8'h80, 8'h00, 0);               // R9
    run(8'hCF, 8'h00, 1);
    run(8'h00, 8'h00, 0);
    load(6, 8'hFF);                     // R5 low nibble masked
    run(8'hCE, 8'h00, 0);
    load(7, 8'h01); load(6, 8'h00);
    run(8'hCE, 8'hFF, 0);               // R3: carry without carry-in
    @(negedge clk);
    start = 1'b1; ld_en = 1'b1; ld_sel = 3'd7; ld_data = 8'h33;
    @(negedge clk);
    start = 1'b0; ld_en = 1'b0;
    @(negedge clk);
    chk("R10", "load ignored with start", acc, r[7]);
    mpc = mpc + 16'd1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule